// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

An up-counter that advances once per clock and wraps from all-ones to zero, with two compare registers that flag when the count reaches them and four capture channels that copy the count on a rising edge of an external pin. One control/status register collects seven event flags and one control bit. The control bit lets a compare-A match restart the count from zero, which gives a programmable period.

Each flag drives its own level interrupt output. Software clears a flag with a two-step handshake. It first reads the status register while the flag is 1, and then writes 0 to that bit. A write of 0 that was not preceded by such a read leaves the flag alone, and writing 1 never sets a flag. The processor reaches the counter, the compare registers, the capture registers and the status register over a single-cycle synchronous register bus with combinational read data.

Top module: `frt_capcmp`

## Requirements
- R1: While reset is asserted, every register reads 0 and every interrupt output is low. Reset is asynchronous active-low and is released synchronously after two clock edges.
- R2: With no bus write and no compare-A clear, the counter increases by exactly 1 per clock and wraps from all-ones to 0.
- R3: The overflow flag (status bit 1) sets on the clock at which an increment carries the counter from all-ones to 0.
- R4: A bus write to the counter (address 0) loads the written value at the next clock. It overrides both the increment and the compare-A clear in that cycle.
- R5: Compare flag A (status bit 3) sets when the counter equals compare register A (address 1). Compare flag B (status bit 2) sets when the counter equals compare register B (address 2). The comparison uses the counter value before that clock's update.
- R6: With the clear-on-match control bit (status bit 0) at 1, a compare-A match makes the counter 0 on the next clock. With the bit at 0, the counter continues to count through the match.
- R7: Each capture pin k (A..D = bit 0..3 of the pin bus) is passed through two synchroniser flops and then a rising-edge detector. On a detected edge, the counter is copied into capture register k (addresses 4..7) and capture flag k is set. Capture flags A..D are status bits 7..4. A pin raised in the cycle in which the counter is loaded with W captures W+1.
- R8: A falling edge on a capture pin changes neither the capture register nor the capture flag.
- R9: A flag clears on a status write (address 3) of 0 to its bit only if a status read returned 1 for that bit since the previous status write. Any status write disarms every bit.
- R10: Writing 1 to status bits 7..1 has no effect. Status bit 0 is a plain read/write bit.
- R11: When a hardware event and a qualified clearing write hit the same flag in the same cycle, the flag stays 1.
- R12: Each flag drives its interrupt output as a level signal: irq_cap[k] for capture channel k, irq_cmp[0] for compare A, irq_cmp[1] for compare B, and irq_ovf for overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 4 | Capture pins, bit k = channel k (A=0) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from the address |
| irq_cap | output | 4 | Capture flag levels |
| irq_cmp | output | 2 | Compare flag levels (0 = A, 1 = B) |
| irq_ovf | output | 1 | Overflow flag level |

## Verification
The bench builds the block with an 8-bit counter and the two-stage synchroniser. Because the counter then has only 256 states, every compare-A value can be swept in both clear modes, and the expected count after each match is computed arithmetically. The same small width makes the wrap from all-ones to zero reachable within a few cycles of a counter load. Captures are swept over all four channels at several load values, including one where the captured value itself wraps.

// File: rtl/frt_pkg.sv
package frt_pkg;

  localparam int unsigned ADR_W  = 3;
  localparam int unsigned CAP_N  = 4;
  localparam int unsigned FLAG_N = CAP_N + 3;

  typedef enum logic [ADR_W-1:0] {
    REG_COUNT = 3'd0,
    REG_CMPA  = 3'd1,
    REG_CMPB  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_CAPA  = 3'd4,
    REG_CAPB  = 3'd5,
    REG_CAPC  = 3'd6,
    REG_CAPD  = 3'd7
  } reg_addr_e;

  // flag vector positions; status bit = flag index + 1
  localparam int unsigned FL_OVF  = 0;
  localparam int unsigned FL_CMPB = 1;
  localparam int unsigned FL_CMPA = 2;

  function automatic int unsigned cap_flag_idx(input int unsigned ch);
    return FLAG_N - 1 - ch;
  endfunction

endpackage

// File: rtl/frt_rst_sync.sv
module frt_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/frt_edge_sync.sv
module frt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/frt_flag_cell.sv
module frt_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic arm_o
);

  logic flag_q, flag_d, arm_q, arm_d;
  logic clr;

  always_comb begin
    clr    = wr_i & arm_q & ~wbit_i;
    flag_d = set_i | (flag_q & ~clr);
    arm_d  = wr_i ? 1'b0 : (arm_q | (rd_i & flag_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;

endmodule

// File: rtl/frt_capcmp.sv
module frt_capcmp
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CAP_N-1:0]     cap_in,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADR_W-1:0]     bus_addr,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  output logic [CAP_N-1:0]     irq_cap,
  output logic [1:0]           irq_cmp,
  output logic                 irq_ovf
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic                          srst_n;
  logic [CNT_W-1:0]              cnt_q, cnt_d;
  logic [CNT_W-1:0]              ocra_q, ocrb_q;
  logic [CAP_N-1:0][CNT_W-1:0]   icr_q;
  logic                          clr_a_q;
  logic [CAP_N-1:0]              cap_rise;
  logic [FLAG_N-1:0]             set_vec, flags_q, arm_q;
  logic                          cnt_wr, ocra_wr, ocrb_wr, csr_wr, csr_rd;
  logic                          match_a, match_b, clear_hit, ovf_hit;

  frt_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(srst_n));

  // bus decode
  always_comb begin
    cnt_wr  = bus_sel & bus_wr  & (bus_addr == REG_COUNT);
    ocra_wr = bus_sel & bus_wr  & (bus_addr == REG_CMPA);
    ocrb_wr = bus_sel & bus_wr  & (bus_addr == REG_CMPB);
    csr_wr  = bus_sel & bus_wr  & (bus_addr == REG_CTRL);
    csr_rd  = bus_sel & ~bus_wr & (bus_addr == REG_CTRL);
  end

  // counter next state; matches use the pre-update value
  always_comb begin
    match_a   = (cnt_q == ocra_q);
    match_b   = (cnt_q == ocrb_q);
    clear_hit = clr_a_q & match_a;
    ovf_hit   = (&cnt_q) & ~cnt_wr & ~clear_hit;
    if (cnt_wr)         cnt_d = bus_wdata;
    else if (clear_hit) cnt_d = '0;
    else                cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ocra_q  <= '0;
      ocrb_q  <= '0;
      clr_a_q <= 1'b0;
    end else begin
      if (ocra_wr) ocra_q  <= bus_wdata;
      if (ocrb_wr) ocrb_q  <= bus_wdata;
      if (csr_wr)  clr_a_q <= bus_wdata[0];
    end
  end

  // capture channels
  for (genvar k = 0; k < CAP_N; k++) begin : g_cap
    frt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (srst_n),
      .pin_i (cap_in[k]),
      .rise_o(cap_rise[k])
    );

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)          icr_q[k] <= '0;
      else if (cap_rise[k]) icr_q[k] <= cnt_q;
    end
  end

  // flag event vector
  always_comb begin
    set_vec          = '0;
    set_vec[FL_OVF]  = ovf_hit;
    set_vec[FL_CMPB] = match_b;
    set_vec[FL_CMPA] = match_a;
    for (int k = 0; k < int'(CAP_N); k++) begin
      set_vec[cap_flag_idx(k)] = cap_rise[k];
    end
  end

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    frt_flag_cell u_cell (
      .clk   (clk),
      .rst_n (srst_n),
      .set_i (set_vec[f]),
      .rd_i  (csr_rd),
      .wr_i  (csr_wr),
      .wbit_i(bus_wdata[f+1]),
      .flag_o(flags_q[f]),
      .arm_o (arm_q[f])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_COUNT: bus_rdata = cnt_q;
      REG_CMPA:  bus_rdata = ocra_q;
      REG_CMPB:  bus_rdata = ocrb_q;
      REG_CTRL:  bus_rdata[FLAG_N:0] = {flags_q, clr_a_q};
      default:   bus_rdata = icr_q[bus_addr[1:0]];
    endcase
  end

  // interrupt levels
  always_comb begin
    for (int k = 0; k < int'(CAP_N); k++) begin
      irq_cap[k] = flags_q[cap_flag_idx(k)];
    end
    irq_cmp = {flags_q[FL_CMPB], flags_q[FL_CMPA]};
    irq_ovf = flags_q[FL_OVF];
  end

endmodule

// File: rtl/frt_capcmp_chk.sv
module frt_capcmp_chk
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                        clk,
  input logic                        srst_n,
  input logic [CNT_W-1:0]            bus_wdata,
  input logic                        cnt_wr,
  input logic                        csr_wr,
  input logic [CNT_W-1:0]            cnt_q,
  input logic [CNT_W-1:0]            ocra_q,
  input logic                        clr_a_q,
  input logic [FLAG_N-1:0]           set_vec,
  input logic [FLAG_N-1:0]           flags_q,
  input logic [FLAG_N-1:0]           arm_q,
  input logic [CAP_N-1:0]            cap_rise,
  input logic [CAP_N-1:0][CNT_W-1:0] icr_q
);

  // R3
  a_r3_ovf_on_wrap: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && (cnt_q == '0) && (&$past(cnt_q)) && !$past(cnt_wr)
     && !($past(clr_a_q) && ($past(cnt_q) == $past(ocra_q))))
    |-> flags_q[FL_OVF]);

  // R4
  a_r4_write_wins: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(srst_n) && $past(cnt_wr)) |-> (cnt_q == $past(bus_wdata)));

  // R10: a flag only rises from a hardware event
  a_r10_no_sw_set: assert property (@(posedge clk) disable iff (!srst_n)
    $past(srst_n) |-> ((flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0));

  // R9
  a_r9_clear_needs_arm: assert property (@(posedge clk) disable iff (!srst_n)
    $past(srst_n) |->
      ((~flags_q & $past(flags_q) & ~($past(arm_q) & {FLAG_N{$past(csr_wr)}})) == '0));

  // R11
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!srst_n)
    $past(srst_n) |-> (($past(set_vec) & ~flags_q) == '0));

  // R7
  for (genvar k = 0; k < CAP_N; k++) begin : g_cap_chk
    a_r7_capture_copy: assert property (@(posedge clk) disable iff (!srst_n)
      ($past(srst_n) && $past(cap_rise[k])) |-> (icr_q[k] == $past(cnt_q)));
  end

endmodule

bind frt_capcmp frt_capcmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .bus_wdata(bus_wdata),
  .cnt_wr   (cnt_wr),
  .csr_wr   (csr_wr),
  .cnt_q    (cnt_q),
  .ocra_q   (ocra_q),
  .clr_a_q  (clr_a_q),
  .set_vec  (set_vec),
  .flags_q  (flags_q),
  .arm_q    (arm_q),
  .cap_rise (cap_rise),
  .icr_q    (icr_q)
);

// File: tb/tb_frt_capcmp.sv
module tb_frt_capcmp;

  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;
  localparam logic [2:0] A_CNT = 3'd0, A_OCRA = 3'd1, A_OCRB = 3'd2, A_CSR = 3'd3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   cap_in;
  logic         bus_sel, bus_wr;
  logic [2:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic [3:0]   irq_cap;
  logic [1:0]   irq_cmp;
  logic         irq_ovf;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  frt_capcmp #(.CNT_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cap(irq_cap), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic bus_write(input logic [2:0] a, input int d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = W'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output int d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int d;
    rst_n = 1'b0; cap_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    idle(3);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a); #1;
      chk("R1 reg", int'(bus_rdata), 0);
    end
    chk("R1 irq", int'({irq_cap, irq_cmp, irq_ovf}), 0);
    rst_n = 1'b1;
    idle(4);

    // R6 / R4: exhaustive compare-A sweep in both clear modes
    for (int v = 0; v < 256; v++) begin
      for (int m = 0; m < 2; m++) begin
        bus_write(A_CSR, m);
        bus_write(A_OCRA, v);
        bus_write(A_CNT, (v - 2) & MASK);
        idle(3);
        bus_read(A_CNT, d);
        chk(m ? "R6 clear on match" : "R6 run through", d, m ? 0 : ((v + 1) & MASK));
      end
    end

    // set up directed tests
    bus_write(A_CSR, 0);
    bus_write(A_OCRA, 8'h80);
    bus_write(A_OCRB, 8'h90);
    bus_write(A_CNT, 8'h10);
    bus_read(A_CSR, d);
    bus_write(A_CSR, 0);
    bus_read(A_CSR, d);
    chk("R9 handshake clears all", d, 0);
    chk("R12 irq low", int'({irq_cap, irq_cmp, irq_ovf}), 0);
    bus_write(A_CSR, 8'hFE);
    bus_read(A_CSR, d);
    chk("R10 write one no set", d, 0);
    bus_write(A_CSR, 8'h01);
    bus_read(A_CSR, d);
    chk("R10 bit0 rw", d, 8'h01);
    bus_write(A_CSR, 0);

    // R5 compare A, R9 unarmed write
    bus_write(A_CNT, 8'h7E);
    idle(3);
    bus_write(A_CSR, 0);
    bus_read(A_CSR, d);
    chk("R9 unarmed write keeps flag", d, 8'h08);
    chk("R12 irq_cmp A", int'(irq_cmp), 1);
    bus_write(A_CSR, 0);
    bus_read(A_CSR, d);
    chk("R9 armed write clears", d, 0);

    // R5 compare B
    idle(20);
    bus_read(A_CSR, d);
    chk("R5 compare B flag", d, 8'h04);

    // R11 set wins over clear
    bus_write(A_CNT, 8'h8E);
    idle(2);
    bus_write(A_CSR, 0);
    bus_read(A_CSR, d);
    chk("R11 set beats clear", d, 8'h04);

    // R3 overflow, R2 wrap
    bus_write(A_CNT, 8'hFD);
    idle(3);
    bus_read(A_CNT, d);
    chk("R2 wrap to zero", d, 0);
    bus_read(A_CSR, d);
    chk("R3 overflow flag", d, 8'h06);
    chk("R12 irq_ovf", int'(irq_ovf), 1);

    // R2 increment
    bus_write(A_CNT, 8'h30);
    bus_read(A_CNT, d);
    chk("R2 load", d, 8'h30);
    bus_read(A_CNT, d);
    chk("R2 step", d, 8'h31);
    idle(5);
    bus_read(A_CNT, d);
    chk("R2 count", d, 8'h37);

    // R4 write beats match clear; R5 match uses pre-update value
    bus_write(A_CSR, 8'h01);
    bus_write(A_OCRA, 8'h40);
    bus_write(A_CNT, 8'h3F);
    idle(1);
    bus_write(A_CNT, 8'h20);
    bus_read(A_CNT, d);
    chk("R4 write priority", d, 8'h20);
    bus_read(A_CSR, d);
    chk("R5 pre-update match", (d >> 3) & 1, 1);
    bus_write(A_CSR, 0);

    // R7 / R8 capture sweep
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 256; w += 51) begin
        bus_read(A_CSR, d);
        bus_write(A_CSR, 0);
        cap_in[k] = 1'b1;
        bus_write(A_CNT, w);
        idle(3);
        bus_read(3'(4 + k), d);
        chk("R7 captured value", d, (w + 1) & MASK);
        bus_read(A_CSR, d);
        chk("R7 capture flag", (d >> (7 - k)) & 1, 1);
        chk("R12 irq_cap", int'(irq_cap[k]), 1);
        bus_write(A_CSR, 0);
        cap_in[k] = 1'b0;
        idle(4);
        bus_read(A_CSR, d);
        chk("R8 fall no flag", (d >> (7 - k)) & 1, 0);
        bus_read(3'(4 + k), d);
        chk("R8 fall no capture", d, (w + 1) & MASK);
      end
    end

    summary();
    $finish;
  end

endmodule